// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous memory that accepts one command on every enabled clock edge. The command can be a read, a write, a deselect, or a burst continuation. A read returns its data two enabled edges after the command. A write takes its data from the data-in bus two enabled edges after the command, which is the same slot a read would use. Because of this, any mix of reads and writes can run back to back with no idle cycles between them.

Each command carries three chip enables, a write enable, and one active-low byte select per lane. When the burst control is high, the previous command type repeats at the next address of a four-beat group, in either linear or interleaved order. A clock enable freezes the whole pipeline, including a write that is waiting for its data. The data-out bus comes with a drive-enable flag. The flag is low whenever the output enable is inactive or the current data slot does not belong to a read.

Top module: `zbt_sram_top`

## Requirements
- R1: While reset is active and until the first read reaches its data slot, `dq_oe` is low.
- R2: The data of a read command appears on `dq_out` with `dq_oe` high after the second enabled rising edge that follows the edge that accepted the command.
- R3: A write takes its data from `dq_in` on the second enabled edge after its command. Byte lane b (bits 8b+7..8b) is written only when `bw_n[b]` is 0. With all `bw_n` bits at 1, the word is left unchanged.
- R4: A new command is accepted only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Every other combination is a deselect, which writes nothing and drives nothing in its data slot.
- R5: When `cen_n` is 1, the edge is ignored. No command is taken, no write is committed, and `dq_out` and the slot status hold their values.
- R6: Reads and writes may alternate on consecutive enabled edges. A read issued right after a write to the same address returns the new bytes merged with the unselected old bytes.
- R7: When `adv_ld` is 1 on an enabled edge, the chip enables and `we_n` are ignored. The previous command type (read, write or deselect) repeats at the next burst address. After four beats the address wraps inside its aligned group of four.
- R8: With `burst_lin`=1, the two low address bits of beat n are (start+n) mod 4. With `burst_lin`=0, they are start XOR n. The upper address bits stay fixed during a burst.
- R9: `dq_oe` is low when `oe_n` is 1, and it is low in the data slot of a write or a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cen_n | input | 1 | Clock enable, active low; high stalls everything |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| adv_ld | input | 1 | 1 = continue burst, 0 = load new command |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| bw_n | input | NB | Byte-lane write selects, active low |
| addr | input | AW | Word address |
| oe_n | input | 1 | Output enable, active low |
| dq_in | input | NB*LW | Write data, sampled in the write's data slot |
| dq_out | output | NB*LW | Registered read data |
| dq_oe | output | 1 | Output drive enable (low means high impedance) |

## Verification
The hardest situation to reach is a read that lands one enabled edge after a write to the same word. It gets harder when a stall falls between the two, because the write's data has not yet reached the array when the read samples it. The directed part of the bench sets up this case explicitly with partial byte selects. The random phase keeps addresses inside 32 words and mixes in stalls, bursts, deselects and output-enable toggling. Those choices make write/read collisions on the same word frequent, including collisions during bursts and across stalls.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low address bits of burst beat `beat` starting at `start`
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] beat,
                                              input logic       linear);
    return linear ? (start + beat) : (start ^ beat);
  endfunction

endpackage

// File: rtl/zbt_cmd_stage.sv
module zbt_cmd_stage
  import zbt_sram_pkg::*;
#(
  parameter int AW = 10,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          adv,
  input  logic          sel,
  input  logic          we_n,
  input  logic          linear,
  input  logic [NB-1:0] bw_n,
  input  logic [AW-1:0] addr,
  output op_e           op_q,
  output logic [AW-1:0] addr_q,
  output logic [NB-1:0] bw_q
);

  op_e           op_d, op_r;
  logic [AW-1:0] addr_d, addr_r, base_d, base_r;
  logic [1:0]    beat_d, beat_r;
  logic [NB-1:0] bw_d, bw_r;

  always_comb begin
    op_d   = op_r;
    addr_d = addr_r;
    base_d = base_r;
    beat_d = beat_r;
    bw_d   = bw_n;
    if (adv) begin
      beat_d = beat_r + 2'd1;
      addr_d = {base_r[AW-1:2], burst_offset(base_r[1:0], beat_d, linear)};
    end else if (sel) begin
      op_d   = we_n ? OP_READ : OP_WRITE;
      base_d = addr;
      beat_d = 2'd0;
      addr_d = addr;
    end else begin
      op_d   = OP_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_r   <= OP_NONE;
      addr_r <= '0;
      base_r <= '0;
      beat_r <= '0;
      bw_r   <= '1;
    end else if (en) begin
      op_r   <= op_d;
      addr_r <= addr_d;
      base_r <= base_d;
      beat_r <= beat_d;
      bw_r   <= bw_d;
    end
  end

  assign op_q   = op_r;
  assign addr_q = addr_r;
  assign bw_q   = bw_r;

endmodule

// File: rtl/zbt_byte_array.sv
module zbt_byte_array #(
  parameter int AW = 10,
  parameter int NB = 4,
  parameter int LW = 8,
  localparam int DEPTH = 1 << AW,
  localparam int DW = NB * LW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] waddr,
  input  logic [NB-1:0] wbe,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [LW-1:0] lane [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wbe[b]) lane[waddr] <= wdata[b*LW +: LW];
    end

    assign rdata[b*LW +: LW] = lane[raddr];
  end

endmodule

// File: rtl/zbt_rd_bypass.sv
module zbt_rd_bypass #(
  parameter int NB = 4,
  parameter int LW = 8,
  localparam int DW = NB * LW
) (
  input  logic          hit,
  input  logic [NB-1:0] be,
  input  logic [DW-1:0] arr_data,
  input  logic [DW-1:0] fwd_data,
  output logic [DW-1:0] merged
);

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign merged[b*LW +: LW] = (hit && be[b]) ? fwd_data[b*LW +: LW]
                                               : arr_data[b*LW +: LW];
  end

endmodule

// File: rtl/zbt_sram_top.sv
module zbt_sram_top
  import zbt_sram_pkg::*;
#(
  parameter int AW = 10,
  parameter int NB = 4,
  parameter int LW = 8,
  localparam int DW = NB * LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cen_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          we_n,
  input  logic          adv_ld,
  input  logic          burst_lin,
  input  logic [NB-1:0] bw_n,
  input  logic [AW-1:0] addr,
  input  logic          oe_n,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic en, sel;
  assign en  = ~cen_n;
  assign sel = ~ce1_n & ce2 & ~ce3_n;

  // stage 1: accepted command (load or burst beat)
  op_e           s1_op;
  logic [AW-1:0] s1_addr;
  logic [NB-1:0] s1_bwn;

  zbt_cmd_stage #(.AW(AW), .NB(NB)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (en),
    .adv    (adv_ld),
    .sel    (sel),
    .we_n   (we_n),
    .linear (burst_lin),
    .bw_n   (bw_n),
    .addr   (addr),
    .op_q   (s1_op),
    .addr_q (s1_addr),
    .bw_q   (s1_bwn)
  );

  // stage 2: command waiting for its data slot
  op_e           s2_op_d, s2_op_q;
  logic [AW-1:0] s2_addr_d, s2_addr_q;
  logic [NB-1:0] s2_bwn_d, s2_bwn_q;
  logic [DW-1:0] hold_d, hold_q;
  logic [DW-1:0] dout_d, dout_q;
  logic          slot_rd_d, slot_rd_q;

  logic [DW-1:0] arr_rdata, byp_data;
  logic          wr_commit, fwd_hit;

  assign wr_commit = en && (s2_op_q == OP_WRITE);
  assign fwd_hit   = (s2_op_q == OP_WRITE) && (s2_addr_q == s1_addr);

  zbt_byte_array #(.AW(AW), .NB(NB), .LW(LW)) u_array (
    .clk   (clk),
    .wr_en (wr_commit),
    .waddr (s2_addr_q),
    .wbe   (~s2_bwn_q),
    .wdata (dq_in),
    .raddr (s1_addr),
    .rdata (arr_rdata)
  );

  // write committing on this edge is not yet in the array: merge it in
  zbt_rd_bypass #(.NB(NB), .LW(LW)) u_bypass (
    .hit      (fwd_hit),
    .be       (~s2_bwn_q),
    .arr_data (arr_rdata),
    .fwd_data (dq_in),
    .merged   (byp_data)
  );

  always_comb begin
    s2_op_d   = s1_op;
    s2_addr_d = s1_addr;
    s2_bwn_d  = s1_bwn;
    hold_d    = (s1_op == OP_READ) ? byp_data : hold_q;
    slot_rd_d = (s2_op_q == OP_READ);
    dout_d    = slot_rd_d ? hold_q : dout_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s2_op_q   <= OP_NONE;
      s2_addr_q <= '0;
      s2_bwn_q  <= '1;
      hold_q    <= '0;
      slot_rd_q <= 1'b0;
      dout_q    <= '0;
    end else if (en) begin
      s2_op_q   <= s2_op_d;
      s2_addr_q <= s2_addr_d;
      s2_bwn_q  <= s2_bwn_d;
      hold_q    <= hold_d;
      slot_rd_q <= slot_rd_d;
      dout_q    <= dout_d;
    end
  end

  assign dq_out = dout_q;
  assign dq_oe  = slot_rd_q & ~oe_n;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          srst_n,
  input logic          cen_n,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          we_n,
  input logic          adv_ld,
  input logic          oe_n,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe
);

  logic load_sel;
  assign load_sel = !cen_n && !adv_ld && !ce1_n && ce2 && !ce3_n;

  // R2: a loaded read drives its slot after two more enabled edges
  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (load_sel && we_n) ##1 !cen_n ##1 !cen_n |=> (dq_oe == !oe_n));

  // R4 / R9: deselect or write slots are never driven
  assert_no_drive_slot_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (!cen_n && !adv_ld && (!load_sel || !we_n)) ##1 !cen_n ##1 !cen_n |=> !dq_oe);

  // R5: a stalled edge leaves the output data unchanged
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!srst_n)
    cen_n |=> $stable(dq_out));

  // R9: output enable inactive means no drive
  assert_oe_off_R9: assert property (@(posedge clk) disable iff (!srst_n)
    oe_n |-> !dq_oe);

endmodule

bind zbt_sram_top zbt_sram_chk #(.DW(NB*LW)) u_chk (
  .clk    (clk),
  .srst_n (rst_sync_n),
  .cen_n  (cen_n),
  .ce1_n  (ce1_n),
  .ce2    (ce2),
  .ce3_n  (ce3_n),
  .we_n   (we_n),
  .adv_ld (adv_ld),
  .oe_n   (oe_n),
  .dq_out (dq_out),
  .dq_oe  (dq_oe)
);

// File: tb/zbt_sram_tb.sv
module zbt_sram_top_tb_top;
  localparam int AW = 10;
  localparam int NB = 4;
  localparam int LW = 8;
  localparam int DW = NB * LW;

  logic          clk = 1'b0;
  logic          rst_n, cen_n, ce1_n, ce2, ce3_n, we_n, adv_ld, burst_lin, oe_n;
  logic [NB-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe;

  always #2 clk = ~clk;   // 250 MHz

  zbt_sram_top #(.AW(AW), .NB(NB), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .we_n(we_n), .adv_ld(adv_ld), .burst_lin(burst_lin),
    .bw_n(bw_n), .addr(addr), .oe_n(oe_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  string tag = "R1";

  // reference model state (ops: 0 none, 1 read, 2 write)
  logic [DW-1:0] mem_m [1 << AW];
  int            m1_op = 0, m2_op = 0;
  logic [AW-1:0] m1_addr = '0, m2_addr = '0, m_base = '0;
  logic [NB-1:0] m1_bw = '1, m2_bw = '1;
  logic [1:0]    m_beat = '0;
  logic          exp_rd = 1'b0;
  logic [DW-1:0] exp_dat = '0;

  task automatic chk(input bit ok, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] next_burst_addr(input logic [AW-1:0] base,
                                                    input logic [1:0] beat,
                                                    input logic lin);
    logic [1:0] lo;
    lo = lin ? (base[1:0] + beat) : (base[1:0] ^ beat);
    return {base[AW-1:2], lo};
  endfunction

  task automatic model_edge();
    int nop;
    logic [AW-1:0] na;
    if (cen_n) return;
    if (m2_op == 2)
      for (int b = 0; b < NB; b++)
        if (!bw_n[b] || !m2_bw[b]) begin
          if (!m2_bw[b]) mem_m[m2_addr][b*LW +: LW] = dq_in[b*LW +: LW];
        end
    exp_rd = (m2_op == 1);
    if (m2_op == 1) exp_dat = mem_m[m2_addr];
    m2_op = m1_op; m2_addr = m1_addr; m2_bw = m1_bw;
    na = m1_addr;
    if (adv_ld) begin
      m_beat = m_beat + 2'd1;
      na = next_burst_addr(m_base, m_beat, burst_lin);
      nop = m1_op;
    end else if (!ce1_n && ce2 && !ce3_n) begin
      nop = we_n ? 1 : 2;
      m_base = addr; m_beat = 2'd0; na = addr;
    end else begin
      nop = 0;
    end
    m1_op = nop; m1_addr = na; m1_bw = bw_n;
  endtask

  // one clock: inputs already set at a negedge; sample at the next negedge
  task automatic cyc();
    logic e_oe;
    dq_in = {$urandom, $urandom};
    model_edge();
    @(posedge clk);
    @(negedge clk);
    e_oe = exp_rd && !oe_n;
    chk(dq_oe == e_oe, "dq_oe", {31'd0, dq_oe}, {31'd0, e_oe});
    if (e_oe) chk(dq_out == exp_dat, "dq_out", dq_out, exp_dat);
  endtask

  task automatic put(input logic cen, input logic c1, input logic c2, input logic c3,
                     input logic we, input logic adv, input logic [NB-1:0] bw,
                     input logic [AW-1:0] a, input logic oe);
    cen_n = cen; ce1_n = c1; ce2 = c2; ce3_n = c3; we_n = we; adv_ld = adv;
    bw_n = bw; addr = a; oe_n = oe;
    cyc();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] bw);
    put(0, 0, 1, 0, 0, 0, bw, a, 0);
  endtask
  task automatic rd(input logic [AW-1:0] a);
    put(0, 0, 1, 0, 1, 0, '1, a, 0);
  endtask
  task automatic idle();
    put(0, 1, 1, 0, 1, 0, '1, '0, 0);
  endtask
  task automatic adv(input logic [NB-1:0] bw);
    put(0, 1, 0, 1, 1, 1, bw, '0, 0);  // enables/we deliberately inactive
  endtask
  task automatic stall();
    put(1, 0, 1, 0, 0, 0, '0, 10'h3ff, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 0; cen_n = 1; ce1_n = 1; ce2 = 0; ce3_n = 1; we_n = 1; adv_ld = 0;
    burst_lin = 1; bw_n = '1; addr = '0; oe_n = 0; dq_in = '0;
    for (int i = 0; i < 1 << AW; i++) mem_m[i] = '0;
    // R1: reset state
    tag = "R1";
    repeat (3) begin
      @(negedge clk);
      chk(dq_oe == 1'b0, "dq_oe in reset", {31'd0, dq_oe}, '0);
    end
    rst_n = 1;
    repeat (4) idle();

    // R3: fill words 0..31 with full writes
    tag = "R3";
    for (int i = 0; i < 32; i++) wr(AW'(i), 4'b0000);
    idle(); idle();
    // R2: plain read latency
    tag = "R2";
    rd(10'd5); idle(); idle(); idle();
    rd(10'd3); rd(10'd4); idle(); idle();
    // R3: partial and empty byte writes
    tag = "R3";
    wr(10'd6, 4'b1010); idle(); idle(); rd(10'd6); idle(); idle();
    wr(10'd6, 4'b1111); idle(); idle(); rd(10'd6); idle(); idle();
    // R6: alternation and read right after write to the same word
    tag = "R6";
    wr(10'd7, 4'b0110); rd(10'd7); wr(10'd7, 4'b1100); rd(10'd7);
    rd(10'd8); wr(10'd8, 4'b0001); rd(10'd8); idle(); idle(); idle();
    // R7: linear write burst from 18 -> 18,19,16,17, then read it back
    tag = "R7";
    burst_lin = 1;
    wr(10'd18, 4'b0000); adv(4'b0000); adv(4'b0011); adv(4'b0000);
    rd(10'd18); adv('1); adv('1); adv('1);
    put(0, 1, 1, 0, 0, 0, '0, 10'd20, 0); adv(4'b0000); adv(4'b0000); // deselect burst
    idle(); rd(10'd21); idle(); idle(); idle();
    // R8: interleaved read burst from 17 -> 17,16,19,18
    tag = "R8";
    burst_lin = 0;
    rd(10'd17); adv('1); adv('1); adv('1); adv('1); idle(); idle(); idle();
    wr(10'd25, 4'b0000); adv(4'b0000); adv(4'b0000); adv(4'b0000);
    burst_lin = 1;
    rd(10'd24); adv('1); adv('1); adv('1); idle(); idle(); idle();
    // R4: every non-select enable combination writes nothing
    tag = "R4";
    for (int c = 0; c < 8; c++) begin
      if (c != 3'b010) put(0, c[2], c[1], c[0], 0, 0, 4'b0000, 10'd9, 0);
    end
    idle(); idle(); rd(10'd9); idle(); idle(); idle();
    // R5: stalls hold pending writes and outputs
    tag = "R5";
    wr(10'd10, 4'b0000); stall(); stall(); idle(); stall(); idle(); rd(10'd10);
    idle(); stall(); idle(); stall(); stall(); stall(); idle(); idle();
    wr(10'd11, 4'b0101); stall(); rd(10'd11); stall(); stall(); idle(); idle(); idle();
    // R9: output enable and write slots
    tag = "R9";
    put(0, 0, 1, 0, 1, 0, '1, 10'd5, 1); put(0, 1, 1, 0, 1, 0, '1, 0, 1);
    put(0, 1, 1, 0, 1, 0, '1, 0, 1); put(0, 1, 1, 0, 1, 0, '1, 0, 0);
    wr(10'd12, 4'b0000); wr(10'd13, 4'b0000); idle(); idle(); idle();

    // random mix
    tag = "R6";
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [NB-1:0] bw;
      r = int'($urandom % 100);
      bw = NB'($urandom);
      burst_lin = 1'($urandom);
      if (r < 10) stall();
      else if (r < 35) adv(bw);
      else if (r < 45) put(0, 1'($urandom), 1'($urandom), 1, 1'($urandom), 0, bw,
                           AW'($urandom % 32), 1'($urandom % 4 == 0));
      else if (r < 70) wr(AW'($urandom % 32), bw);
      else put(0, 0, 1, 0, 1, 0, '1, AW'($urandom % 32), 1'($urandom % 8 == 0));
    end
    repeat (4) idle();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL %s watchdog actual=running expected=finished", tag);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule